// File: doc/BRIEF.md
# LRU Stack Distance Profiler

This block watches a stream of page numbers and keeps them in a recency-ordered stack of distinct pages, with the most recently used page at the top. Each reference is looked up in the stack. On a hit, the block increments the counter for the depth at which the page was found and moves the page to the top. On a miss, it increments a separate cold-miss counter and pushes the page onto the top. When the stack is full, a push drops the least recent page off the bottom.

After a single pass over a trace, the counters form a histogram of reuse distances. From this histogram the number of faults under least-recently-used replacement can be read for any buffer size k. That fault count is the cold-miss count plus every counter deeper than k. Every reference is handled the same way, whatever kind of access produced it.

Two read ports are provided:
- a histogram port, which reads one counter selected by depth;
- a fault port, which returns the fault total for a requested buffer size.

Top module: `lru_depth_profiler`

## Requirements
- R1: After reset, `ref_ready` is 1, every depth counter and the cold-miss counter are zero, and the stack is empty.
- R2: A reference is accepted on a rising clock edge where `ref_valid` and `ref_ready` are both 1. `ref_ready` is then 0 for exactly two cycles. A `ref_valid` pulse while `ref_ready` is 0 is ignored.
- R3: A page that is not in the stack increments the cold-miss counter and becomes the top entry. `hist_sel` = 0 reads the cold-miss counter.
- R4: A page found at depth d, where d = 1 is the most recent, increments the counter for depth d. `hist_sel` = d reads that counter, for 1 ≤ d ≤ DEPTH. The page moves to depth 1, and the entries that were above it each move one depth down.
- R5: Referencing the same page twice in a row records a hit at depth 1.
- R6: The stack holds DEPTH distinct pages. A new page pushed onto a full stack evicts the entry at depth DEPTH. The next reference to the evicted page counts as a cold miss.
- R7: With `buf_pages` = k, `fault_count` is the cold-miss count plus the sum of the counters for depths k+1 through DEPTH. For k = 0 this is the total number of accepted references. For k ≥ DEPTH it is the cold-miss count alone.
- R8: A `hist_sel` value above DEPTH reads zero.
- R9: Both read outputs are registered. Each shows the counters as they stood before the clock edge that loads the output register. An update committed at that same edge appears on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_valid | input | 1 | Reference strobe |
| ref_page | input | PAGE_W | Page number of the reference |
| ref_ready | output | 1 | Block can accept a reference |
| hist_sel | input | SEL_W | Depth to read; 0 selects the cold-miss counter |
| hist_count | output | CNT_W | Registered counter value for `hist_sel` |
| buf_pages | input | SEL_W | Buffer size k for the fault readout |
| fault_count | output | CNT_W | Registered fault total for `buf_pages` |

## Verification
A counter update and a readout can fall in the same cycle. The update commits on the edge that returns the block to ready, and the read registers sample the counters on that same edge. The bench holds `buf_pages` at 0 while a reference is in flight. It then compares `fault_count` in the first ready cycle, which must still show the old total, with the value one cycle later, which must include the new reference. A `ref_valid` pulse during the busy cycles is also provoked, and is judged by the cold-miss count and by the later depth at which that page is found.

// File: rtl/lru_depth_profiler.sv
module lru_depth_profiler #(
  parameter int PAGE_W = 12,
  parameter int DEPTH  = 64,
  parameter int CNT_W  = 24,
  localparam int SEL_W = $clog2(DEPTH + 1),
  localparam int POS_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_valid,
  input  logic [PAGE_W-1:0] ref_page,
  output logic              ref_ready,
  input  logic [SEL_W-1:0]  hist_sel,
  output logic [CNT_W-1:0]  hist_count,
  input  logic [SEL_W-1:0]  buf_pages,
  output logic [CNT_W-1:0]  fault_count
);

  typedef enum logic [1:0] {ST_IDLE, ST_FIND, ST_MOVE} st_t;
  st_t st;

  logic [PAGE_W-1:0] stk_page [DEPTH];
  logic [DEPTH-1:0]  stk_vld;
  logic [CNT_W-1:0]  dist_cnt [DEPTH];
  logic [CNT_W-1:0]  cold_cnt;
  logic [PAGE_W-1:0] cur_page;
  logic              hit_q, hit_c;
  logic [POS_W-1:0]  pos_q, pos_c, lim;
  logic [CNT_W-1:0]  fsum, hsel;

  assign ref_ready = (st == ST_IDLE);
  assign lim = hit_q ? pos_q : POS_W'(DEPTH - 1);

  always_comb begin
    hit_c = 1'b0;
    pos_c = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (stk_vld[i] && stk_page[i] == cur_page) begin
        hit_c = 1'b1;
        pos_c = POS_W'(i);
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= ST_IDLE;
      cur_page <= '0;
      hit_q    <= 1'b0;
      pos_q    <= '0;
    end else begin
      case (st)
        ST_IDLE: if (ref_valid) begin
          cur_page <= ref_page;
          st       <= ST_FIND;
        end
        ST_FIND: begin
          hit_q <= hit_c;
          pos_q <= pos_c;
          st    <= ST_MOVE;
        end
        default: st <= ST_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stk_vld  <= '0;
      cold_cnt <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        stk_page[i] <= '0;
        dist_cnt[i] <= '0;
      end
    end else if (st == ST_MOVE) begin
      for (int i = 1; i < DEPTH; i++)
        if (POS_W'(i) <= lim) begin
          stk_page[i] <= stk_page[i-1];
          stk_vld[i]  <= stk_vld[i-1];
        end
      stk_page[0] <= cur_page;
      stk_vld[0]  <= 1'b1;
      if (hit_q) dist_cnt[pos_q] <= dist_cnt[pos_q] + 1'b1;
      else       cold_cnt        <= cold_cnt + 1'b1;
    end

  always_comb begin
    fsum = cold_cnt;
    for (int j = 0; j < DEPTH; j++)
      if (SEL_W'(j) >= buf_pages) fsum = fsum + dist_cnt[j];
  end

  always_comb begin
    if (hist_sel == '0)                 hsel = cold_cnt;
    else if (hist_sel <= SEL_W'(DEPTH)) hsel = dist_cnt[POS_W'(hist_sel - 1'b1)];
    else                                hsel = '0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hist_count  <= '0;
      fault_count <= '0;
    end else begin
      hist_count  <= hsel;
      fault_count <= fsum;
    end

endmodule

// File: rtl/lru_depth_profiler_chk.sv
module lru_depth_profiler_chk #(
  parameter int DEPTH = 64,
  parameter int SEL_W = 7,
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_valid,
  input logic             ref_ready,
  input logic [SEL_W-1:0] hist_sel,
  input logic [CNT_W-1:0] hist_count,
  input logic [SEL_W-1:0] buf_pages,
  input logic [CNT_W-1:0] fault_count
);

  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid && ref_ready |=> !ref_ready); // R2

  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid && ref_ready |=> !ref_ready ##1 !ref_ready ##1 ref_ready); // R2

  AST_READY_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $fell(ref_ready) |-> $past(ref_valid)); // R2

  AST_FAULT_INCLUDES_COLD: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(hist_sel) == '0 |-> fault_count >= hist_count); // R7

  AST_FAULT_COLD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(hist_sel) == '0 && $past(buf_pages) >= SEL_W'(DEPTH)
      |-> fault_count == hist_count); // R7

  AST_OVERRANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(hist_sel) > SEL_W'(DEPTH) |-> hist_count == '0); // R8

endmodule

bind lru_depth_profiler lru_depth_profiler_chk #(
  .DEPTH(DEPTH), .SEL_W(SEL_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_ready(ref_ready),
  .hist_sel(hist_sel), .hist_count(hist_count),
  .buf_pages(buf_pages), .fault_count(fault_count)
);

// File: tb/sim_lru_depth_profiler.sv
module sim_lru_depth_profiler;
  localparam int CLK_PERIOD = 10;
  localparam int PAGE_W = 12;
  localparam int DEPTH  = 64;
  localparam int CNT_W  = 24;
  localparam int SEL_W  = $clog2(DEPTH + 1);
  localparam int NV = 10;
  // page stream and the hand-derived depth of each reference (0 = cold)
  localparam int VPAGE [NV] = '{10, 20, 30, 10, 10, 30, 20, 40, 10, 20};
  localparam int VDIST [NV] = '{ 0,  0,  0,  3,  1,  2,  3,  0,  4,  3};

  logic clk = 1'b0, rst_n = 1'b0, ref_valid = 1'b0;
  logic [PAGE_W-1:0] ref_page = '0;
  logic [SEL_W-1:0] hist_sel = '0, buf_pages = '0;
  logic ref_ready;
  logic [CNT_W-1:0] hist_count, fault_count;
  int total = 0, bad = 0;
  int exp_hist [DEPTH+1];

  always #(CLK_PERIOD/2) clk = ~clk;

  lru_depth_profiler #(.PAGE_W(PAGE_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_page(ref_page),
    .ref_ready(ref_ready), .hist_sel(hist_sel), .hist_count(hist_count),
    .buf_pages(buf_pages), .fault_count(fault_count));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int page, output int busy);
    ref_page = PAGE_W'(page);
    ref_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ref_valid = 1'b0;
    busy = 0;
    while (!ref_ready) begin
      busy++;
      @(negedge clk);
    end
  endtask

  task automatic rd(input int sel, input int k, output int h, output int f);
    hist_sel = SEL_W'(sel);
    buf_pages = SEL_W'(k);
    @(negedge clk);
    h = int'(hist_count);
    f = int'(fault_count);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i <= DEPTH; i++) exp_hist[i] = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int h, f, busy, exp_f;
    do_reset();
    // R1: reset state
    check(ref_ready == 1'b1, "R1 ready", int'(ref_ready), 1);
    rd(0, 0, h, f);
    check(h == 0, "R1 cold", h, 0);
    check(f == 0, "R1 faults", f, 0);
    rd(1, 0, h, f);
    check(h == 0, "R1 depth1", h, 0);

    // vector walk: R3 cold, R4 depth hits, R5 repeat at depth 1, R7 k=0 total
    for (int v = 0; v < NV; v++) begin
      send(VPAGE[v], busy);
      if (v == 0) check(busy == 2, "R2 busy cycles", busy, 2);
      exp_hist[VDIST[v]]++;
      rd(VDIST[v], 0, h, f);
      check(h == exp_hist[VDIST[v]], VDIST[v] == 0 ? "R3 cold count" :
            (VDIST[v] == 1 ? "R5 depth1 hit" : "R4 depth hit"), h, exp_hist[VDIST[v]]);
      check(f == v + 1, "R7 k=0 total", f, v + 1);
    end

    // R7: fault totals for several buffer sizes from the bench histogram
    for (int k = 1; k <= 5; k++) begin
      exp_f = exp_hist[0];
      for (int d = k + 1; d <= DEPTH; d++) exp_f += exp_hist[d];
      rd(0, k, h, f);
      check(f == exp_f, "R7 fault for k", f, exp_f);
    end
    rd(DEPTH + 1, 0, h, f);
    check(h == 0, "R8 out of range", h, 0);

    // R9: update and readout in the same cycle
    buf_pages = '0;
    hist_sel = '0;
    send(20, busy);
    check(int'(fault_count) == NV, "R9 old value first", int'(fault_count), NV);
    @(negedge clk);
    check(int'(fault_count) == NV + 1, "R9 new value next", int'(fault_count), NV + 1);
    exp_hist[1]++;

    // R2: strobe during busy is ignored
    ref_page = PAGE_W'(50);
    ref_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ref_page = PAGE_W'(60);
    @(negedge clk);
    ref_valid = 1'b0;
    while (!ref_ready) @(negedge clk);
    exp_hist[0]++;
    rd(0, 0, h, f);
    check(h == exp_hist[0], "R2 busy strobe cold", h, exp_hist[0]);
    send(60, busy);
    exp_hist[0]++;
    rd(0, 0, h, f);
    check(h == exp_hist[0], "R2 ignored page absent", h, exp_hist[0]);

    // R6: fill the stack, evict, then re-reference
    do_reset();
    for (int p = 100; p <= 100 + DEPTH; p++) send(p, busy);
    send(101, busy);
    rd(DEPTH, 0, h, f);
    check(h == 1, "R6 deepest hit", h, 1);
    send(100, busy);
    rd(0, 0, h, f);
    check(h == DEPTH + 2, "R6 evicted is cold", h, DEPTH + 2);
    rd(0, DEPTH, h, f);
    check(f == DEPTH + 2, "R7 k=DEPTH cold only", f, DEPTH + 2);
    rd(0, DEPTH - 1, h, f);
    check(f == DEPTH + 3, "R7 k=DEPTH-1", f, DEPTH + 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule